// File: doc/BRIEF.md
# String Operand Pointer Sequencer

This block drives the address side of the repeated string primitives (move, load, store, compare, scan). A start pulse loads a source index, a destination index, a repeat count and two segment bases. It also latches three mode bits: the pointer direction, byte or word operands, and whether a repeat prefix is present. For each iteration the block raises a request and presents two physical addresses. The source address is formed from the data segment and the source index. The destination address is formed from the extra segment and the destination index. The request is held until an acknowledge arrives. The acknowledge stands in for the memory datapath, which lies outside this block.

When an iteration is acknowledged, both indices move by the operand size, up or down as the direction bit selects. With a repeat prefix the count also drops by one, and it is tested before every iteration, so a zero count ends the run at once. Without the prefix exactly one iteration runs. At the end the block pulses done, and the final indices and count stay on the outputs for the surrounding logic to write back.

Top module: `str_ptr_seq`

## Requirements
- R1: While req is high, src_addr equals (data segment × 16 + source index) modulo 2^20.
- R2: While req is high, dst_addr equals (extra segment × 16 + destination index) modulo 2^20.
- R3: On each acknowledged iteration both indices increase when dir_dec is 0 and decrease when dir_dec is 1.
- R4: The index step is 1 when word_op is 0 (bytes) and 2 when word_op is 1 (words).
- R5: Index arithmetic wraps modulo 2^16, and address sums that exceed 20 bits are truncated.
- R6: With rep_en set and a count N greater than 0, exactly N requests are issued, the count drops by one on each acknowledge, and cx_out reads 0 at done.
- R7: With rep_en set and a count of 0, done is raised without any request, and the indices and the count keep their loaded values.
- R8: With rep_en clear, exactly one request is issued and cx_out keeps its loaded value.
- R9: A request stays high, with stable addresses, until ack is sampled high. ack has no effect while req is low.
- R10: done is a single-cycle pulse raised in the cycle after the final acknowledge, or after the zero-count check. A start pulse while busy is ignored.
- R11: After reset the block is idle, with req, done and busy low and the index and count outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a sequence when the block is idle |
| rep_en | input | 1 | Repeat prefix present |
| dir_dec | input | 1 | 1 means decrement the indices, 0 means increment |
| word_op | input | 1 | 1 means word operands, 0 means byte operands |
| seg_data | input | 16 | Data segment base |
| seg_extra | input | 16 | Extra segment base |
| si_in | input | 16 | Initial source index |
| di_in | input | 16 | Initial destination index |
| cx_in | input | 16 | Initial repeat count |
| ack | input | 1 | Current iteration's access is complete |
| req | output | 1 | Iteration access requested |
| src_addr | output | 20 | Source physical address |
| dst_addr | output | 20 | Destination physical address |
| si_out | output | 16 | Current source index |
| di_out | output | 16 | Current destination index |
| cx_out | output | 16 | Current repeat count |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions run on every cycle and cover the local step rules. A pending request holds with stable addresses. Every acknowledge moves the indices by the signed step and either decrements or preserves the count. A repeat that finds a zero count issues no request. done never lasts more than one cycle. The whole-run properties can only be seen in the bench's scenarios. These are the exact number of requests per sequence, the address values against independently tracked indices, wrap-around at the 16-bit and 20-bit limits, and the fact that stray start or ack pulses leave the sequence unchanged.

// File: rtl/str_ptr_seq.sv
module str_ptr_seq #(
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 20,
  parameter int SHIFT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rep_en,
  input  logic              dir_dec,
  input  logic              word_op,
  input  logic [IDX_W-1:0]  seg_data,
  input  logic [IDX_W-1:0]  seg_extra,
  input  logic [IDX_W-1:0]  si_in,
  input  logic [IDX_W-1:0]  di_in,
  input  logic [IDX_W-1:0]  cx_in,
  input  logic              ack,
  output logic              req,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [IDX_W-1:0]  si_out,
  output logic [IDX_W-1:0]  di_out,
  output logic [IDX_W-1:0]  cx_out,
  output logic              busy,
  output logic              done
);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_ACCESS} state_t;

  state_t             state;
  logic               rep_q, dec_q, word_q;
  logic [IDX_W-1:0]   ds_q, es_q, si_q, di_q, cx_q;
  logic [IDX_W-1:0]   step;
  logic [IDX_W-1:0]   si_nxt, di_nxt;

  assign step   = word_q ? IDX_W'(2) : IDX_W'(1);
  assign si_nxt = dec_q ? si_q - step : si_q + step;
  assign di_nxt = dec_q ? di_q - step : di_q + step;

  assign req      = (state == S_ACCESS);
  assign busy     = (state != S_IDLE);
  assign src_addr = (ADDR_W'(ds_q) << SHIFT) + ADDR_W'(si_q);
  assign dst_addr = (ADDR_W'(es_q) << SHIFT) + ADDR_W'(di_q);
  assign si_out   = si_q;
  assign di_out   = di_q;
  assign cx_out   = cx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rep_q  <= 1'b0;
      dec_q  <= 1'b0;
      word_q <= 1'b0;
      ds_q   <= '0;
      es_q   <= '0;
      si_q   <= '0;
      di_q   <= '0;
      cx_q   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          rep_q  <= rep_en;
          dec_q  <= dir_dec;
          word_q <= word_op;
          ds_q   <= seg_data;
          es_q   <= seg_extra;
          si_q   <= si_in;
          di_q   <= di_in;
          cx_q   <= cx_in;
          state  <= S_CHECK;
        end
        S_CHECK: begin
          if (rep_q && cx_q == '0) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            state <= S_ACCESS;
          end
        end
        S_ACCESS: if (ack) begin
          si_q <= si_nxt;
          di_q <= di_nxt;
          if (rep_q) begin
            cx_q  <= cx_q - IDX_W'(1);
            state <= S_CHECK;
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/str_ptr_seq_chk.sv
module str_ptr_seq_chk #(
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              ack,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [IDX_W-1:0]  si_out,
  input logic [IDX_W-1:0]  di_out,
  input logic [IDX_W-1:0]  cx_out,
  input logic              rep_q,
  input logic              dec_q,
  input logic              word_q
);
  logic [IDX_W-1:0] stp;
  assign stp = word_q ? IDX_W'(2) : IDX_W'(1);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(src_addr) && $stable(dst_addr)));

  p_idle_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ack) |=> ($stable(si_out) && $stable(di_out) && $stable(cx_out)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=>
      (si_out == ($past(dec_q) ? $past(si_out) - $past(stp) : $past(si_out) + $past(stp))) &&
      (di_out == ($past(dec_q) ? $past(di_out) - $past(stp) : $past(di_out) + $past(stp))));

  p_cx_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && rep_q) |=> (cx_out == $past(cx_out) - IDX_W'(1)));

  p_cx_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && !rep_q) |=> ($stable(cx_out) && done));

  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req && rep_q && cx_out == '0) |=> (!req && done));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind str_ptr_seq str_ptr_seq_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .busy(busy), .done(done),
  .src_addr(src_addr), .dst_addr(dst_addr), .si_out(si_out), .di_out(di_out),
  .cx_out(cx_out), .rep_q(rep_q), .dec_q(dec_q), .word_q(word_q));

// File: tb/str_ptr_seq_bench.sv
module str_ptr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, rep_en = 1'b0, dir_dec = 1'b0, word_op = 1'b0, ack = 1'b0;
  logic [15:0] seg_data = '0, seg_extra = '0, si_in = '0, di_in = '0, cx_in = '0;
  logic        req, busy, done;
  logic [19:0] src_addr, dst_addr;
  logic [15:0] si_out, di_out, cx_out;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  str_ptr_seq u_str_ptr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rep_en(rep_en), .dir_dec(dir_dec),
    .word_op(word_op), .seg_data(seg_data), .seg_extra(seg_extra), .si_in(si_in),
    .di_in(di_in), .cx_in(cx_in), .ack(ack), .req(req), .src_addr(src_addr),
    .dst_addr(dst_addr), .si_out(si_out), .di_out(di_out), .cx_out(cx_out),
    .busy(busy), .done(done));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [15:0] e_si, e_di, e_cx;
  int          e_iters;

  task automatic launch(input bit r, input bit d, input bit w, input logic [15:0] ds,
                        input logic [15:0] es, input logic [15:0] s, input logic [15:0] di,
                        input logic [15:0] c);
    @(negedge clk);
    rep_en = r; dir_dec = d; word_op = w; seg_data = ds; seg_extra = es;
    si_in = s; di_in = di; cx_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e_si = s; e_di = di; e_cx = c; e_iters = 0;
  endtask

  task automatic serve(input bit r, input bit d, input bit w, input logic [15:0] ds,
                       input logic [15:0] es, input int dly, input string tag);
    logic [15:0] st;
    logic [19:0] es_a, ed_a;
    int guard;
    st = w ? 16'd2 : 16'd1;
    guard = 0;
    while (!done && guard < 2000) begin
      guard++;
      if (req) begin
        es_a = 20'({ds, 4'h0}) + 20'(e_si);
        ed_a = 20'({es, 4'h0}) + 20'(e_di);
        chk(src_addr == es_a, {tag, " R1 src"}, 32'(src_addr), 32'(es_a));
        chk(dst_addr == ed_a, {tag, " R2 dst"}, 32'(dst_addr), 32'(ed_a));
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          chk(req && src_addr == es_a, {tag, " R9 hold"}, 32'(src_addr), 32'(es_a));
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        e_si = d ? e_si - st : e_si + st;
        e_di = d ? e_di - st : e_di + st;
        if (r) e_cx = e_cx - 16'd1;
        e_iters++;
      end else begin
        @(negedge clk);
      end
    end
    chk(done, {tag, " R10 done seen"}, 32'(done), 32'd1);
    chk(si_out == e_si, {tag, " R3/R4 si"}, 32'(si_out), 32'(e_si));
    chk(di_out == e_di, {tag, " R3/R4 di"}, 32'(di_out), 32'(e_di));
    chk(cx_out == e_cx, {tag, " R6/R8 cx"}, 32'(cx_out), 32'(e_cx));
    @(negedge clk);
    chk(!done && !busy, {tag, " R10 pulse"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    chk(!req && !done && !busy, "R11 ctl", {29'd0, req, done, busy}, 32'd0);
    chk(si_out == 0 && di_out == 0 && cx_out == 0, "R11 regs", 32'(si_out), 32'd0);
  endtask

  task automatic t_single_byte_inc();
    launch(0, 0, 0, 16'h1000, 16'h2000, 16'h0010, 16'h0020, 16'h0007);
    serve(0, 0, 0, 16'h1000, 16'h2000, 0, "single byte inc");
    chk(e_iters == 1, "R8 one iteration", 32'(e_iters), 32'd1);
  endtask

  task automatic t_single_word_dec();
    launch(0, 1, 1, 16'h0ABC, 16'h0DEF, 16'h0100, 16'h0200, 16'h0005);
    serve(0, 1, 1, 16'h0ABC, 16'h0DEF, 2, "single word dec");
    chk(e_iters == 1 && cx_out == 16'h0005, "R8 cx kept", 32'(cx_out), 32'h5);
  endtask

  task automatic t_rep_byte_inc();
    launch(1, 0, 0, 16'h0040, 16'h0080, 16'h0003, 16'h0103, 16'd5);
    serve(1, 0, 0, 16'h0040, 16'h0080, 1, "rep byte inc");
    chk(e_iters == 5, "R6 count", 32'(e_iters), 32'd5);
  endtask

  task automatic t_rep_word_dec();
    launch(1, 1, 1, 16'h3000, 16'h4000, 16'h0050, 16'h0060, 16'd4);
    serve(1, 1, 1, 16'h3000, 16'h4000, 0, "rep word dec");
    chk(e_iters == 4 && cx_out == 0, "R6 word count", 32'(e_iters), 32'd4);
  endtask

  task automatic t_rep_zero();
    launch(1, 0, 1, 16'h0001, 16'h0002, 16'h1234, 16'h5678, 16'd0);
    serve(1, 0, 1, 16'h0001, 16'h0002, 0, "rep zero");
    chk(e_iters == 0, "R7 no request", 32'(e_iters), 32'd0);
    chk(si_out == 16'h1234 && di_out == 16'h5678, "R7 regs kept", 32'(si_out), 32'h1234);
  endtask

  task automatic t_wrap();
    launch(1, 0, 1, 16'hFFFF, 16'hFFF0, 16'hFFFE, 16'hFFFF, 16'd2);
    serve(1, 0, 1, 16'hFFFF, 16'hFFF0, 0, "wrap up");
    chk(si_out == 16'h0002, "R5 si wrap", 32'(si_out), 32'h2);
    launch(1, 1, 0, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'd3);
    serve(1, 1, 0, 16'h0000, 16'h0000, 0, "wrap down");
    chk(si_out == 16'hFFFD && di_out == 16'hFFFE, "R5 dec wrap", 32'(si_out), 32'hFFFD);
  endtask

  task automatic t_ack_ignored();
    logic [15:0] s0, d0, c0;
    s0 = si_out; d0 = di_out; c0 = cx_out;
    @(negedge clk);
    ack = 1'b1;
    repeat (3) @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
    chk(!req && !busy && si_out == s0 && di_out == d0 && cx_out == c0,
        "R9 idle ack ignored", 32'(si_out), 32'(s0));
  endtask

  task automatic t_start_busy();
    launch(1, 0, 0, 16'h0100, 16'h0200, 16'h0010, 16'h0020, 16'd3);
    start = 1'b1; si_in = 16'h7777; di_in = 16'h8888; cx_in = 16'd9; rep_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    serve(1, 0, 0, 16'h0100, 16'h0200, 0, "start while busy");
    chk(e_iters == 3, "R10 start ignored", 32'(e_iters), 32'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single_byte_inc();
    t_single_word_dec();
    t_rep_byte_inc();
    t_rep_word_dec();
    t_rep_zero();
    t_wrap();
    t_ack_ignored();
    t_start_busy();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule